// File: doc/BRIEF.md
# Residue-Checked Integer Arithmetic Unit

This unit adds, subtracts or multiplies two unsigned W-bit operands and produces the exact, full-precision result. Alongside the main datapath runs a small residue datapath. It reduces each operand modulo a small number, applies the same operation to those residues, and compares the outcome with the residue of the main result. Any mismatch raises an error flag. This catches corruption of the result that the main adder or multiplier may suffer.

A parameter selects the strength of the checker. The single form uses modulus 3. The dual form runs modulus 3 and modulus 5 side by side and ORs their mismatches, so an error escapes only when its value change is a multiple of 15. An XOR injection mask is applied to the main result before the checker sees it, so a test can model upsets in the result. The mask never reaches the residue path or the comparators. Result, valid and flags are registered together one cycle after the input strobe.

Top module: `resid_alu`

## Requirements
- R1: With op_i = 2'b00, res_o is the W+1-bit sum of a_i and b_i, including the carry, zero-extended to 2W bits.
- R2: With op_i = 2'b01, res_o is the W+1-bit two's-complement value a_i - b_i, sign-extended to 2W bits.
- R3: With op_i = 2'b10, res_o is the full 2W-bit product of a_i and b_i.
- R4: op_i = 2'b11 is unchecked: res_o becomes zero whatever the mask is, and no error flag rises.
- R5: vld_o is in_vld_i delayed by one clock. Result and flags update in that same cycle. While vld_o is low all flags are low and res_o holds its last value.
- R6: An all-zero inj_mask_i never raises err_m3_o, err_m5_o or err_o.
- R7: For add, subtract and multiply, any mask with exactly one bit set, at any of the 2W positions, raises err_o in both configurations.
- R8: err_m3_o rises exactly when the residue mod 3 of the delivered result differs from the residue computed from a_i mod 3 and b_i mod 3. For subtract, the delivered result is read as a signed 2W-bit value.
- R9: With DUAL = 1, err_m5_o follows the same rule with modulus 5 and err_o is the OR of both flags. With DUAL = 0, err_m5_o stays low and err_o equals err_m3_o.
- R10: A mask that adds exactly 15 to the result (mask 4'hF on a result whose low four bits are zero) escapes both checks. A mask that adds exactly 3 escapes mod 3 but is caught by mod 5.
- R11: During and right after reset, vld_o, res_o and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Operand strobe |
| op_i | input | 2 | 00 add, 01 subtract, 10 multiply, 11 unchecked (zero) |
| a_i | input | W | First operand, unsigned |
| b_i | input | W | Second operand, unsigned |
| inj_mask_i | input | 2W | XOR mask applied to the main result |
| res_o | output | 2W | Registered exact result |
| vld_o | output | 1 | Registered strobe |
| err_m3_o | output | 1 | Mod 3 mismatch |
| err_m5_o | output | 1 | Mod 5 mismatch (dual form only) |
| err_o | output | 1 | Combined error |

## Verification
The bench sweeps a one-hot mask across every result bit for each operation. The high bits matter most: in subtract mode the value is signed, so flipping the sign bit changes it by a large power of two. A checker that read the difference as unsigned, or that truncated the sum or product, would miss flips in those upper bits or flag clean negative differences. Random operands with a zero mask catch wrong residue reduction, in particular a mod 5 digit sign placed on the wrong digit or a subtract residue that goes negative without being corrected. The escape cases pin down the detection boundary. The +15 mask must pass both moduli, and the +3 mask must be seen only by mod 5. A design that mixed up the two flags, or failed to OR them, shows up here. It also shows up in a single-modulus copy that runs in parallel.

// File: rtl/resid_alu.sv
module resid_alu #(
  parameter int W    = 32,
  parameter bit DUAL = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld_i,
  input  logic [1:0]      op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [2*W-1:0]  inj_mask_i,
  output logic [2*W-1:0]  res_o,
  output logic            vld_o,
  output logic            err_m3_o,
  output logic            err_m5_o,
  output logic            err_o
);
  localparam int RW = 2 * W;
  localparam int ND = RW / 2;
  localparam int K5 = (W % 2 == 1) ? 4 : 1;

  function automatic int fold3(input logic [RW-1:0] v);
    int s;
    s = 0;
    for (int i = 0; i < ND; i++) s += int'(v[2*i +: 2]);
    return s % 3;
  endfunction

  function automatic int fold5(input logic [RW-1:0] v);
    int s;
    s = 0;
    for (int i = 0; i < ND; i++)
      if (i % 2 == 0) s += int'(v[2*i +: 2]);
      else            s -= int'(v[2*i +: 2]);
    s = s % 5;
    return (s < 0) ? s + 5 : s;
  endfunction

  logic [RW-1:0] a_x, b_x, exact, deliv;
  logic [W:0]    sum_w, dif_w;
  logic          chk, sgn, mis3, mis5;
  int            ra3, rb3, ra5, rb5, exp3, exp5, obs3, obs5;

  assign a_x   = RW'(a_i);
  assign b_x   = RW'(b_i);
  assign sum_w = {1'b0, a_i} + {1'b0, b_i};
  assign dif_w = {1'b0, a_i} - {1'b0, b_i};
  assign chk   = (op_i != 2'b11);

  always_comb begin
    case (op_i)
      2'b00:   exact = RW'(sum_w);
      2'b01:   exact = {{(RW-W-1){dif_w[W]}}, dif_w};
      2'b10:   exact = a_x * b_x;
      default: exact = '0;
    endcase
  end

  assign deliv = chk ? (exact ^ inj_mask_i) : '0;
  assign sgn   = (op_i == 2'b01) && deliv[RW-1];

  always_comb begin
    ra3 = fold3(a_x);
    rb3 = fold3(b_x);
    ra5 = fold5(a_x);
    rb5 = fold5(b_x);
    case (op_i)
      2'b00:   begin exp3 = (ra3 + rb3) % 3;     exp5 = (ra5 + rb5) % 5;     end
      2'b01:   begin exp3 = (ra3 + 3 - rb3) % 3; exp5 = (ra5 + 5 - rb5) % 5; end
      default: begin exp3 = (ra3 * rb3) % 3;     exp5 = (ra5 * rb5) % 5;     end
    endcase
    obs3 = (fold3(deliv) + (sgn ? 2 : 0)) % 3;
    obs5 = (fold5(deliv) + (sgn ? 5 - K5 : 0)) % 5;
  end

  assign mis3 = chk && (obs3 != exp3);
  assign mis5 = DUAL && chk && (obs5 != exp5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o    <= 1'b0;
      res_o    <= '0;
      err_m3_o <= 1'b0;
      err_m5_o <= 1'b0;
    end else begin
      vld_o    <= in_vld_i;
      err_m3_o <= in_vld_i && mis3;
      err_m5_o <= in_vld_i && mis5;
      if (in_vld_i) res_o <= deliv;
    end
  end

  assign err_o = err_m3_o | err_m5_o;

  AST_ZERO_MASK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld_i && inj_mask_i == '0) |=> !err_o) else $error("zero mask flagged"); // R6
  AST_ONE_BIT_CAUGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld_i && chk && $countones(inj_mask_i) == 1) |=> err_o) else $error("single flip missed"); // R7
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld_i |=> vld_o) else $error("valid lost"); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld_i |=> (!vld_o && !err_o && $stable(res_o))) else $error("idle activity"); // R5
  AST_UNCHECKED_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld_i && op_i == 2'b11) |=> (res_o == '0 && !err_o)) else $error("op 3 misbehaved"); // R4
endmodule

// File: tb/resid_alu_tb_top.sv
`timescale 1ns/1ps
module resid_alu_tb_top;
  localparam int W  = 32;
  localparam int RW = 2 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [1:0] op = 2'b00;
  logic [W-1:0] a = '0, b = '0;
  logic [RW-1:0] mask = '0;
  logic [RW-1:0] res_d, res_s;
  logic vld_d, e3_d, e5_d, e_d, vld_s, e3_s, e5_s, e_s;

  int n_chk = 0, n_fail = 0;
  logic [RW-1:0] last_res = '0;

  always #4 clk = ~clk;

  resid_alu #(.W(W), .DUAL(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld_i(in_vld), .op_i(op), .a_i(a), .b_i(b),
    .inj_mask_i(mask), .res_o(res_d), .vld_o(vld_d), .err_m3_o(e3_d),
    .err_m5_o(e5_d), .err_o(e_d));

  resid_alu #(.W(W), .DUAL(1'b0)) dut_s_i (
    .clk(clk), .rst_n(rst_n), .in_vld_i(in_vld), .op_i(op), .a_i(a), .b_i(b),
    .inj_mask_i(mask), .res_o(res_s), .vld_o(vld_s), .err_m3_o(e3_s),
    .err_m5_o(e5_s), .err_o(e_s));

  task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int rmod(input logic [RW-1:0] v, input bit sgn, input int m);
    longint s;
    int r;
    if (sgn) begin
      s = longint'(v);
      r = int'(s % longint'(m));
      if (r < 0) r += m;
    end else begin
      r = int'(v % RW'(m));
    end
    return r;
  endfunction

  task automatic step(input bit v, input logic [1:0] o, input logic [W-1:0] x,
                      input logic [W-1:0] y, input logic [RW-1:0] mk, input string tag);
    logic [RW-1:0] ex, dl;
    logic [W:0] d;
    bit sg, m3, m5;
    in_vld = v; op = o; a = x; b = y; mask = mk;
    d = {1'b0, x} - {1'b0, y};
    case (o)
      2'b00:   ex = RW'({1'b0, x} + {1'b0, y});
      2'b01:   ex = {{(RW-W-1){d[W]}}, d};
      2'b10:   ex = RW'(x) * RW'(y);
      default: ex = '0;
    endcase
    dl = (o == 2'b11) ? '0 : ex ^ mk;
    sg = (o == 2'b01);
    m3 = v && (o != 2'b11) && (rmod(dl, sg, 3) != rmod(ex, sg, 3));
    m5 = v && (o != 2'b11) && (rmod(dl, sg, 5) != rmod(ex, sg, 5));
    if (v) last_res = dl;
    @(negedge clk);
    check({tag, " R5 vld"}, RW'(vld_d), RW'(v));
    check({tag, " res"}, res_d, last_res);
    check({tag, " R8 m3"}, RW'(e3_d), RW'(m3));
    check({tag, " R9 m5"}, RW'(e5_d), RW'(m5));
    check({tag, " R9 err"}, RW'(e_d), RW'(m3 | m5));
    check({tag, " R9 single m5"}, RW'(e5_s), '0);
    check({tag, " R9 single err"}, RW'(e_s), RW'(m3));
    check({tag, " single res"}, res_s, last_res);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset vld", RW'(vld_d), '0);
    check("R11 reset res", res_d, '0);
    check("R11 reset err", RW'(e_d | e3_d | e5_d), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset", RW'(vld_d | e_d), '0);

    step(1, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, '0, "R1 carry");
    check("R1 sum", res_d, 64'h1_FFFF_FFFE);
    step(1, 2'b01, 32'd5, 32'd9, '0, "R2 negative");
    check("R2 diff", res_d, 64'hFFFF_FFFF_FFFF_FFFC);
    step(1, 2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, '0, "R3 max");
    check("R3 prod", res_d, 64'hFFFF_FFFE_0000_0001);
    step(1, 2'b11, 32'd7, 32'd9, 64'h1, "R4 unchecked");
    check("R4 zero", res_d, '0);
    step(0, 2'b00, 32'd1, 32'd1, 64'h1, "R5 idle");

    for (int i = 0; i < 90; i++)
      step(1, 2'($urandom_range(0, 2)), $urandom, $urandom, '0, "R6 random");
    step(1, 2'b01, 32'd0, 32'hFFFF_FFFF, '0, "R6 min diff");

    for (int o = 0; o < 3; o++)
      for (int p = 0; p < RW; p++) begin
        step(1, 2'(o), $urandom, $urandom, RW'(1) << p, "R7 one-hot");
        check("R7 flagged dual", RW'(e_d), RW'(1));
        check("R7 flagged single", RW'(e_s), RW'(1));
      end

    step(1, 2'b00, 32'd16, 32'd0, 64'hF, "R10 plus15");
    check("R10 escape dual", RW'(e_d), '0);
    step(1, 2'b00, 32'd16, 32'd0, 64'h3, "R10 plus3");
    check("R10 m3 miss", RW'(e3_d), '0);
    check("R10 m5 hit", RW'(e5_d), RW'(1));
    check("R10 single miss", RW'(e_s), '0);
    step(0, 2'b00, 32'd0, 32'd0, '0, "R5 tail");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule